// File: doc/BRIEF.md
# Double-Buffered Crosspoint Selector

This block routes a set of single-bit data inputs to a set of outputs through one independent multiplexer per output. Any output may take any input, so one input may drive several outputs at once. The default size is 64 inputs and 33 outputs. Outputs 0 to 31 are addressed ports. The last output is a monitor port.

Routing is set in two stages. A program stage holds one pending input selection per output. It is written one output at a time with a load strobe, or with a separate monitor strobe for the monitor port. Writing this stage never disturbs the traffic. A commit strobe copies every pending selection into the active stage, which drives the multiplexers. While commit is high the multiplexers already see the pending values, so the new routing appears in the cycle the strobe is sampled high. If load and commit are high together, the selection on the input-address bus reaches the routing in the same cycle.

Reset forces every output to input 0. If the first action after reset is a commit, with no program write before it, the block installs a pass-through pattern instead of a plain copy. The most significant input-address bit chooses the low half or the high half of the inputs. All strobes are sampled on the rising clock edge. The data path is combinational.

Top module: `xps_crosspoint`

## Requirements
- R1: While `rst` is high, every output, including the monitor, carries input 0, whatever the strobes and `in_sel` are doing. Reset also clears every pending selection to input 0.
- R2: Several outputs may select the same input at the same time, and each of them carries that input.
- R3: A clock edge with `load_stb` high writes `in_sel` into the pending selection of output `out_sel`. Other pending selections keep their values, and the routing does not change until a commit.
- R4: In a cycle with `cfg_stb` high, every output follows its pending selection. After `cfg_stb` falls, the last committed routing holds.
- R5: With `load_stb` and `cfg_stb` both high, output `out_sel` routes the input named by `in_sel` in that same cycle.
- R6: `mon_stb` writes `in_sel` into the pending selection of the monitor output, and ignores both `out_sel` and `load_stb`. It takes effect at the next commit.
- R7: If the first strobe after reset is `cfg_stb` with `in_sel[5]` low, then output i routes input i for i = 0 to 31, and the monitor routes input 0.
- R8: If the first strobe after reset is `cfg_stb` with `in_sel[5]` high, then output i routes input 32+i, and the monitor routes input 0.
- R9: A commit that follows a program write, or a commit that is not the first after reset, is a plain copy of the pending selections, whatever `in_sel` holds.
- R10: A pass-through commit held high for several cycles keeps the pass-through routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all strobes are sampled |
| rst | input | 1 | Active-high reset: broadcast of input 0 |
| data_in | input | 64 | Single-bit data inputs |
| data_out | output | 33 | Routed outputs; bit 32 is the monitor port |
| in_sel | input | 6 | Input address; its MSB picks the pass-through half |
| out_sel | input | 5 | Output address for `load_stb` writes |
| load_stb | input | 1 | Writes `in_sel` into the pending selection of `out_sel` |
| mon_stb | input | 1 | Writes `in_sel` into the pending selection of the monitor |
| cfg_stb | input | 1 | Commits all pending selections to the routing |

## Verification
The pass-through patterns are the hardest to reach, because they exist only for one commit that directly follows reset with no write before it. Any stray strobe closes that window. The bench therefore pulses reset again before each pass-through scenario, and issues the commit as the very first non-idle cycle. Further commits then show that the pattern is stored and is not re-derived from `in_sel`. Each route is checked with a one-hot data word and then its inverse, so that a wrong selection cannot match by accident.

// File: rtl/xps_pkg.sv
package xps_pkg;
   // input index that output idx takes in a pass-through commit
   function automatic int unsigned thru_code(int unsigned idx, bit hi_half, int unsigned n_out);
      return hi_half ? (n_out + idx) : idx;
   endfunction
endpackage

// File: rtl/xps_prog_bank.sv
module xps_prog_bank #(
   parameter int N_IN  = 64,
   parameter int N_OUT = 32,
   parameter int IW    = 6,
   parameter int OW    = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load_stb,
   input  logic                     mon_stb,
   input  logic                     cfg_stb,
   input  logic [IW-1:0]            in_sel,
   input  logic [OW-1:0]            out_sel,
   output logic [N_OUT:0][IW-1:0]   prog_nxt
);
   logic [N_OUT:0][IW-1:0] prog_q;
   logic                   pt_ok;
   logic                   thru;

   initial begin
      assert (N_IN >= 2 * N_OUT) else $error("xps_prog_bank: N_IN must cover both pass-through halves");
   end

   assign thru = pt_ok && cfg_stb && !load_stb && !mon_stb;

   for (genvar g = 0; g < N_OUT; g++) begin : g_port
      always_comb begin
         if (thru)
            prog_nxt[g] = IW'(xps_pkg::thru_code(g, in_sel[IW-1], N_OUT));
         else if (load_stb && (out_sel == OW'(g)))
            prog_nxt[g] = in_sel;
         else
            prog_nxt[g] = prog_q[g];
      end
   end

   // monitor: ignores out_sel and load_stb, untouched by pass-through
   assign prog_nxt[N_OUT] = mon_stb ? in_sel : prog_q[N_OUT];

   always_ff @(posedge clk) begin
      if (rst) begin
         prog_q <= '0;
         pt_ok  <= 1'b1;
      end else begin
         prog_q <= prog_nxt;
         if (load_stb || mon_stb || cfg_stb)
            pt_ok <= 1'b0;
      end
   end

   // R3: addressed write lands
   a_r3_load_write: assert property (@(posedge clk) disable iff (rst)
      load_stb |=> (prog_q[$past(out_sel)] == $past(in_sel)));
   // R3: other ports keep their pending value
   a_r3_keep_other: assert property (@(posedge clk) disable iff (rst)
      (load_stb && (out_sel != '0)) |=> $stable(prog_q[0]));
   // R6: monitor write ignores address
   a_r6_mon_write: assert property (@(posedge clk) disable iff (rst)
      mon_stb |=> (prog_q[N_OUT] == $past(in_sel)));
   // R9: window closes after any strobe
   a_r9_window_shut: assert property (@(posedge clk) disable iff (rst)
      (load_stb || mon_stb || cfg_stb) |=> !pt_ok);
   // R7 / R8: pass-through stores pattern at port 1
   a_r7_thru_store: assert property (@(posedge clk) disable iff (rst)
      thru |=> (prog_q[1] == ($past(in_sel[IW-1]) ? IW'(N_OUT + 1) : IW'(1))));
endmodule

// File: rtl/xps_cfg_bank.sv
module xps_cfg_bank #(
   parameter int N_OUT = 32,
   parameter int IW    = 6
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_stb,
   input  logic [N_OUT:0][IW-1:0]   prog_nxt,
   output logic [N_OUT:0][IW-1:0]   sel
);
   logic [N_OUT:0][IW-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (rst)
         cfg_q <= '0;
      else if (cfg_stb)
         cfg_q <= prog_nxt;
   end

   // commit is seen by the multiplexers while the strobe is high
   always_comb begin
      if (rst)
         sel = '0;
      else if (cfg_stb)
         sel = prog_nxt;
      else
         sel = cfg_q;
   end

   // R4: active routing holds without commit
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !cfg_stb |=> $stable(cfg_q));
   // R4: committed value matches what was routed during the strobe
   a_r4_commit: assert property (@(posedge clk) disable iff (rst)
      cfg_stb |=> (cfg_q == $past(sel)));
endmodule

// File: rtl/xps_route_mux.sv
module xps_route_mux #(
   parameter int N_IN  = 64,
   parameter int N_OUT = 32,
   parameter int IW    = 6
) (
   input  logic [N_IN-1:0]          data_in,
   input  logic [N_OUT:0][IW-1:0]   sel,
   output logic [N_OUT:0]           data_out
);
   for (genvar o = 0; o <= N_OUT; o++) begin : g_mux
      if (N_IN == (1 << IW)) begin : g_full
         assign data_out[o] = data_in[sel[o]];
      end else begin : g_guard
         assign data_out[o] = (int'(sel[o]) < N_IN) ? data_in[sel[o]] : 1'b0;
      end
   end
endmodule

// File: rtl/xps_crosspoint.sv
module xps_crosspoint #(
   parameter int N_IN  = 64,
   parameter int N_OUT = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [N_IN-1:0]       data_in,
   output logic [N_OUT:0]        data_out,
   input  logic [$clog2(N_IN)-1:0]  in_sel,
   input  logic [$clog2(N_OUT)-1:0] out_sel,
   input  logic                  load_stb,
   input  logic                  mon_stb,
   input  logic                  cfg_stb
);
   localparam int IW = $clog2(N_IN);
   localparam int OW = $clog2(N_OUT);

   initial begin
      assert (N_OUT >= 2 && N_IN >= 2) else $error("xps_crosspoint: sizes too small");
   end

   logic [N_OUT:0][IW-1:0] prog_nxt;
   logic [N_OUT:0][IW-1:0] sel;

   xps_prog_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .IW(IW), .OW(OW)) u_prog (
      .clk(clk), .rst(rst), .load_stb(load_stb), .mon_stb(mon_stb),
      .cfg_stb(cfg_stb), .in_sel(in_sel), .out_sel(out_sel), .prog_nxt(prog_nxt));

   xps_cfg_bank #(.N_OUT(N_OUT), .IW(IW)) u_cfg (
      .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .prog_nxt(prog_nxt), .sel(sel));

   xps_route_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .IW(IW)) u_mux (
      .data_in(data_in), .sel(sel), .data_out(data_out));

   // R1: reset broadcasts input 0 on every port
   a_r1_reset_bcast: assert property (@(posedge clk)
      rst |-> (data_out == {(N_OUT+1){data_in[0]}}));
   // R5: load with commit is transparent to the addressed port
   a_r5_transparent: assert property (@(posedge clk) disable iff (rst)
      (load_stb && cfg_stb) |-> (data_out[out_sel] == data_in[in_sel]));
endmodule

// File: tb/xps_crosspoint_bench.sv
module xps_crosspoint_bench;
   localparam int CLK_NS = 10;
   localparam int WD_CYC = 5000;
   localparam int NV     = 17;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] data_in = '0;
   logic [32:0] data_out;
   logic [5:0]  in_sel = '0;
   logic [4:0]  out_sel = '0;
   logic        load_stb = 1'b0, mon_stb = 1'b0, cfg_stb = 1'b0;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   xps_crosspoint u_xps_crosspoint (
      .clk(clk), .rst(rst), .data_in(data_in), .data_out(data_out),
      .in_sel(in_sel), .out_sel(out_sel), .load_stb(load_stb),
      .mon_stb(mon_stb), .cfg_stb(cfg_stb));

   // {req[3:0], ld, cf, mn, in_sel[5:0], out_sel[4:0], chk_port[5:0], chk_input[5:0]}
   localparam logic [29:0] VEC [NV] = '{
      {4'd3, 1'b1,1'b0,1'b0, 6'd5,  5'd3,  6'd3,  6'd0 },  // R3 write 3<-5, no effect
      {4'd3, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd3,  6'd0 },  // R3 still old routing
      {4'd3, 1'b1,1'b0,1'b0, 6'd40, 5'd7,  6'd7,  6'd0 },  // R3 write 7<-40
      {4'd4, 1'b0,1'b1,1'b0, 6'd0,  5'd0,  6'd3,  6'd5 },  // R4 commit seen at once
      {4'd4, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd7,  6'd40},  // R4 held after commit
      {4'd3, 1'b1,1'b0,1'b0, 6'd9,  5'd3,  6'd3,  6'd5 },  // R3 rewrite pending only
      {4'd5, 1'b1,1'b1,1'b0, 6'd63, 5'd3,  6'd3,  6'd63},  // R5 load+commit transparent
      {4'd5, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd3,  6'd63},  // R5 held
      {4'd6, 1'b0,1'b0,1'b1, 6'd17, 5'd3,  6'd32, 6'd0 },  // R6 monitor write
      {4'd6, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd32, 6'd0 },  // R6 not yet applied
      {4'd6, 1'b0,1'b1,1'b0, 6'd0,  5'd0,  6'd32, 6'd17},  // R6 applied by commit
      {4'd6, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd3,  6'd63},  // R6 out_sel ignored
      {4'd2, 1'b1,1'b0,1'b0, 6'd40, 5'd0,  6'd0,  6'd0 },  // R2 write 0<-40
      {4'd2, 1'b1,1'b0,1'b0, 6'd40, 5'd31, 6'd31, 6'd0 },  // R2 write 31<-40
      {4'd2, 1'b0,1'b1,1'b0, 6'd0,  5'd0,  6'd0,  6'd40},  // R2 commit
      {4'd2, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd31, 6'd40},  // R2 multicast
      {4'd2, 1'b0,1'b0,1'b0, 6'd0,  5'd0,  6'd7,  6'd40}   // R2 multicast
   };

   task automatic drive(input logic ld, input logic cf, input logic mn,
                        input logic [5:0] is, input logic [4:0] os);
      @(negedge clk);
      load_stb = ld; cfg_stb = cf; mon_stb = mn; in_sel = is; out_sel = os;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 6'd0, 5'd0);
   endtask

   // route check: one-hot then inverted one-hot on the expected input
   task automatic chk(input int port, input int exp_in, input string req);
      logic a, b;
      #1 data_in = '0; data_in[exp_in] = 1'b1;
      #1 a = data_out[port];
      data_in = '1; data_in[exp_in] = 1'b0;
      #1 b = data_out[port];
      n_run++;
      if (!(a == 1'b1 && b == 1'b0)) begin
         n_fail++;
         $display("FAIL %s: port %0d got hi/lo %b%b, expected input %0d (10)", req, port, a, b, exp_in);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst = 1'b1;
      load_stb = 0; cfg_stb = 0; mon_stb = 0; in_sel = '0; out_sel = '0;
      @(negedge clk); rst = 1'b0;
   endtask

   initial begin
      // R1: reset broadcast, strobes ignored
      drive(1'b0, 1'b1, 1'b0, 6'd63, 5'd0);
      chk(0, 0, "R1"); chk(17, 0, "R1"); chk(32, 0, "R1");
      @(negedge clk); rst = 1'b0; cfg_stb = 0; in_sel = '0;
      chk(5, 0, "R1");

      // R7: low pass-through as first commit
      drive(1'b0, 1'b1, 1'b0, 6'd0, 5'd0);
      chk(5, 5, "R7"); chk(31, 31, "R7"); chk(32, 0, "R7");
      // R10: commit held, in_sel now irrelevant
      drive(1'b0, 1'b1, 1'b0, 6'd32, 5'd0);
      chk(5, 5, "R10"); chk(20, 20, "R10");
      idle();
      chk(17, 17, "R7"); chk(0, 0, "R7");

      // R8: high pass-through
      pulse_reset();
      chk(17, 0, "R1");
      drive(1'b0, 1'b1, 1'b0, 6'd32, 5'd0);
      chk(0, 32, "R8"); chk(31, 63, "R8"); chk(32, 0, "R8");
      idle();
      // R9: second commit is a plain copy
      drive(1'b0, 1'b1, 1'b0, 6'd0, 5'd0);
      chk(0, 32, "R9"); chk(12, 44, "R9");
      idle();

      // table walk from a clean reset
      pulse_reset();
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22:17], VEC[i][16:12]);
         chk(int'(VEC[i][11:6]), int'(VEC[i][5:0]), $sformatf("R%0d", VEC[i][29:26]));
      end

      // R9: write before commit blocks pass-through; R1 pending cleared
      pulse_reset();
      drive(1'b1, 1'b0, 1'b0, 6'd50, 5'd2);
      drive(1'b0, 1'b1, 1'b0, 6'd0, 5'd0);
      chk(2, 50, "R9"); chk(1, 0, "R9");
      idle();
      chk(1, 0, "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got no finish, expected finish within %0d cycles", WD_CYC);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule